// File: doc/BRIEF.md
# Pulse Rate Meter with Sliding One-Minute Window

This block watches an asynchronous pulse line and reports two rates. It counts low-to-high transitions of the line. At every one-second boundary it publishes two values: how many transitions fell into the second that just closed, and how many fell into the last sixty closed seconds. Both values stay constant between boundaries. A single-cycle update strobe marks the clock cycle in which the new pair appears.

The second length is a parameter given in clock cycles. With a 1000 Hz system clock it is 1000. The window length and the count width are also parameters. The minute figure is a true sliding window. A circular history holds one count per second. A running total adds the newest second and removes the second that falls out of the window, so the total never has to be summed over the whole history. Until a full window has elapsed after reset, the empty history slots hold zero, so the minute value is the sum over the seconds seen so far.

Top module: `pulse_rate_meter`

## Requirements
- R1: Only low-to-high transitions of `pulse_i` are counted, after a two-stage synchronizer. A line held high or held low adds nothing, however long it stays there.
- R2: At each boundary, `sec_count_o` takes the number of transitions credited to the second that just closed. A transition detected in the boundary cycle itself is credited to the new second. No transition is lost or counted twice.
- R3: At each boundary, `min_count_o` takes the sum of the per-second counts of the last `WINDOW` closed seconds. When fewer seconds than that have closed since reset, it takes the sum of all of them. It is never smaller than `sec_count_o`.
- R4: `update_o` is high for exactly one cycle per second. It rises in the cycle in which both counts take their new values. The counts hold their values in every cycle in which `update_o` is low.
- R5: The per-second count stops at 2^`CNT_W`-1 and does not wrap. With `CNT_W`=16 that limit is 65535.
- R6: `min_count_o` shows the exact window sum limited to 2^`CNT_W`-1. Once older seconds leave the window and the sum falls below that limit, it again shows the exact sum.
- R7: A synchronous active-high `rst` clears the history, the running sum, both counts, the strobe and the timebase. The first boundary then follows `TICKS_PER_SEC` cycles after the first cycle without reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| pulse_i | input | 1 | Raw asynchronous pulse line |
| sec_count_o | output | CNT_W | Transitions in the last closed second |
| min_count_o | output | CNT_W | Transitions in the last WINDOW closed seconds, limited to its maximum |
| update_o | output | 1 | One-cycle strobe when both counts change |

## Verification
The bench runs with a short second so that the window slides fully more than once. The stimulus is chosen to hit the corner cases:
- A pulse period of 7 cycles moves transitions across every phase of the boundary. A design that credits a boundary transition to the closing second, or drops it, gives counts that are off by one.
- A line held high for several seconds catches a design that counts levels.
- Dense toggling pushes both counts to their limit. A wrapping counter would fall back to small values.
- A long quiet stretch lets the saturated window drain. A design that kept the limited value inside its running sum would then fall to wrong numbers or underflow.
- A reset in the middle of the run checks that no stale history comes back.

// File: rtl/pulse_rate_pkg.sv
package pulse_rate_pkg;

    localparam int DEF_TICKS_PER_SEC = 1000;
    localparam int DEF_WINDOW        = 60;
    localparam int DEF_CNT_W         = 16;

    // events produced each cycle by the front end and the timebase
    typedef struct packed {
        logic boundary;   // last cycle of the current second
        logic hit;        // synchronized rising transition seen
    } rate_ev_t;

    // width of the running window sum so that WINDOW full counts fit
    function automatic int sum_width(input int cnt_w, input int window);
        return cnt_w + $clog2(window + 1);
    endfunction

endpackage

// File: rtl/pulse_edge_sync.sv
module pulse_edge_sync (
    input  logic clk,
    input  logic rst,
    input  logic raw_i,
    output logic rise_o
);
    logic stage_a, stage_b, stage_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_a    <= 1'b0;
            stage_b    <= 1'b0;
            stage_prev <= 1'b0;
        end else begin
            stage_a    <= raw_i;
            stage_b    <= stage_a;
            stage_prev <= stage_b;
        end
    end

    assign rise_o = stage_b & ~stage_prev;

    // R1
    no_double_rise_chk: assert property (@(posedge clk) disable iff (rst)
        rise_o |=> !rise_o);

endmodule

// File: rtl/pulse_timebase.sv
module pulse_timebase #(
    parameter int TICKS_PER_SEC = pulse_rate_pkg::DEF_TICKS_PER_SEC
) (
    input  logic clk,
    input  logic rst,
    output logic boundary_o
);
    localparam int TB_W = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
    localparam logic [TB_W-1:0] LAST = TB_W'(TICKS_PER_SEC - 1);

    logic [TB_W-1:0] phase_q;

    always_ff @(posedge clk) begin
        if (rst || phase_q == LAST) phase_q <= '0;
        else                        phase_q <= phase_q + 1'b1;
    end

    assign boundary_o = (phase_q == LAST);

    // R7
    phase_restart_chk: assert property (@(posedge clk) disable iff (rst)
        boundary_o |=> (phase_q == '0));

endmodule

// File: rtl/pulse_sec_counter.sv
module pulse_sec_counter #(
    parameter int CNT_W = pulse_rate_pkg::DEF_CNT_W
) (
    input  logic                     clk,
    input  logic                     rst,
    input  pulse_rate_pkg::rate_ev_t ev_i,
    output logic [CNT_W-1:0]         count_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] count_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
        end else if (ev_i.boundary) begin
            // a transition in the boundary cycle opens the new second
            count_q <= ev_i.hit ? CNT_W'(1) : '0;
        end else if (ev_i.hit && count_q != CNT_MAX) begin
            count_q <= count_q + 1'b1;
        end
    end

    assign count_o = count_q;

    // R5
    no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (count_q == CNT_MAX && !ev_i.boundary) |=> (count_q == CNT_MAX));

endmodule

// File: rtl/pulse_window_sum.sv
module pulse_window_sum #(
    parameter int CNT_W  = pulse_rate_pkg::DEF_CNT_W,
    parameter int WINDOW = pulse_rate_pkg::DEF_WINDOW
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  push_i,
    input  logic [CNT_W-1:0]      newest_i,
    output logic [pulse_rate_pkg::sum_width(CNT_W, WINDOW)-1:0] sum_next_o
);
    localparam int SW    = pulse_rate_pkg::sum_width(CNT_W, WINDOW);
    localparam int PTR_W = (WINDOW > 1) ? $clog2(WINDOW) : 1;
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(WINDOW - 1);
    localparam logic [SW-1:0]    SUM_CAP  = SW'(WINDOW) * SW'({CNT_W{1'b1}});

    logic [CNT_W-1:0] slot_q [WINDOW];
    logic [PTR_W-1:0] ptr_q;
    logic [SW-1:0]    sum_q;
    logic [CNT_W-1:0] oldest;

    assign oldest     = slot_q[ptr_q];
    // the oldest slot is part of sum_q, so this never goes below zero
    assign sum_next_o = sum_q + SW'(newest_i) - SW'(oldest);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < WINDOW; i++) slot_q[i] <= '0;
            ptr_q <= '0;
            sum_q <= '0;
        end else if (push_i) begin
            slot_q[ptr_q] <= newest_i;
            ptr_q         <= (ptr_q == PTR_LAST) ? '0 : ptr_q + 1'b1;
            sum_q         <= sum_next_o;
        end
    end

    // R6
    sum_bounded_chk: assert property (@(posedge clk) disable iff (rst)
        sum_q <= SUM_CAP);

    // R3
    sum_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !push_i |=> $stable(sum_q));

endmodule

// File: rtl/pulse_rate_meter.sv
module pulse_rate_meter #(
    parameter int TICKS_PER_SEC = pulse_rate_pkg::DEF_TICKS_PER_SEC,
    parameter int WINDOW        = pulse_rate_pkg::DEF_WINDOW,
    parameter int CNT_W         = pulse_rate_pkg::DEF_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pulse_i,
    output logic [CNT_W-1:0] sec_count_o,
    output logic [CNT_W-1:0] min_count_o,
    output logic             update_o
);
    localparam int SW = pulse_rate_pkg::sum_width(CNT_W, WINDOW);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    pulse_rate_pkg::rate_ev_t ev;
    logic [CNT_W-1:0] cur_sec;
    logic [SW-1:0]    win_next;
    logic [CNT_W-1:0] win_limited;
    logic             hist_ok;

    pulse_edge_sync u_sync (
        .clk    (clk),
        .rst    (rst),
        .raw_i  (pulse_i),
        .rise_o (ev.hit)
    );

    pulse_timebase #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_tb (
        .clk        (clk),
        .rst        (rst),
        .boundary_o (ev.boundary)
    );

    pulse_sec_counter #(.CNT_W(CNT_W)) u_sec (
        .clk     (clk),
        .rst     (rst),
        .ev_i    (ev),
        .count_o (cur_sec)
    );

    pulse_window_sum #(.CNT_W(CNT_W), .WINDOW(WINDOW)) u_win (
        .clk        (clk),
        .rst        (rst),
        .push_i     (ev.boundary),
        .newest_i   (cur_sec),
        .sum_next_o (win_next)
    );

    assign win_limited = (win_next > SW'(CNT_MAX)) ? CNT_MAX : win_next[CNT_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            sec_count_o <= '0;
            min_count_o <= '0;
            update_o    <= 1'b0;
        end else begin
            update_o <= ev.boundary;
            if (ev.boundary) begin
                sec_count_o <= cur_sec;
                min_count_o <= win_limited;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) hist_ok <= 1'b0;
        else     hist_ok <= 1'b1;
    end

    // R4
    strobe_follows_chk: assert property (@(posedge clk) disable iff (rst)
        ev.boundary |=> update_o);

    // R4
    strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
        update_o |=> !update_o);

    // R4
    counts_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (hist_ok && !update_o) |-> ($stable(sec_count_o) && $stable(min_count_o)));

    // R3
    minute_covers_sec_chk: assert property (@(posedge clk) disable iff (rst)
        min_count_o >= sec_count_o);

endmodule

// File: tb/pulse_rate_meter_test.sv
`timescale 1ns/1ps
module pulse_rate_meter_test;
    localparam int T    = 200;
    localparam int WIN  = 60;
    localparam int CW   = 6;
    localparam int MAXV = (1 << CW) - 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pulse_i = 1'b0;
    logic [CW-1:0] sec_count_o, min_count_o;
    logic update_o;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    bit model_on = 0;
    bit done     = 0;

    always #10 clk = ~clk;

    pulse_rate_meter #(.TICKS_PER_SEC(T), .WINDOW(WIN), .CNT_W(CW)) uut (
        .clk(clk), .rst(rst), .pulse_i(pulse_i),
        .sec_count_o(sec_count_o), .min_count_o(min_count_o), .update_o(update_o)
    );

    // behavioural reference
    int smp[$];
    int win[$];
    int phase, acc, exp_sec, exp_min, exp_stb;

    always @(posedge clk) begin
        if (rst) begin
            smp = '{0, 0, 0, 0};
            win.delete();
            phase = 0; acc = 0; exp_sec = 0; exp_min = 0; exp_stb = 0;
            model_on = 1;
        end else if (model_on) begin
            int hit, tot;
            smp.push_back(int'(pulse_i));
            if (smp.size() > 8) void'(smp.pop_front());
            // input seen at edge m-2 high and at m-3 low gives a count at edge m
            hit = (smp[smp.size()-3] == 1 && smp[smp.size()-4] == 0) ? 1 : 0;
            if (phase == T - 1) begin
                phase = 0;
                exp_sec = acc;
                win.push_back(acc);
                if (win.size() > WIN) void'(win.pop_front());
                tot = 0;
                foreach (win[i]) tot += win[i];
                exp_min = (tot > MAXV) ? MAXV : tot;
                exp_stb = 1;
                acc = hit;
            end else begin
                phase++;
                exp_stb = 0;
                if (hit == 1 && acc < MAXV) acc++;
            end
        end
    end

    task automatic check(input string req, input int act, input int expv);
        n_checks++;
        if (act != expv) begin
            n_fail++;
            $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, cycles, act, expv);
        end
    endtask

    always @(negedge clk) begin
        cycles++;
        if (model_on && !done) begin
            check("R2/R5 sec_count", int'(sec_count_o), exp_sec);
            check("R3/R6 min_count", int'(min_count_o), exp_min);
            check("R4 update strobe", int'(update_o), exp_stb);
        end
        if (cycles > 150000 && !done) begin
            done = 1;
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected under 150000", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    task automatic idle(input int n);
        pulse_i = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic train(input int hi, input int lo, input int n);
        repeat (n) begin
            pulse_i = 1'b1; repeat (hi) @(negedge clk);
            pulse_i = 1'b0; repeat (lo) @(negedge clk);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R7: reset state, outputs clear and quiet before the first boundary
        @(negedge clk);
        check("R7 reset sec", int'(sec_count_o), 0);
        check("R7 reset min", int'(min_count_o), 0);
        check("R7 reset strobe", int'(update_o), 0);
        idle(2 * T);
        // R3: sparse pulses, the window grows second by second
        train(3, 37, 5 * 10);
        // R2: period 7 sweeps transitions across the boundary cycle
        train(2, 5, (3 * T) / 7);
        // R1: long high level counts only its leading transition
        pulse_i = 1'b1; repeat (3 * T) @(negedge clk);
        idle(T);
        // R5 and R6: dense toggling drives both counts to the limit
        train(1, 1, 3 * T / 2);
        // R6: the window drains back to exact sums
        idle((WIN + 2) * T);
        // R7: reset in the middle of activity
        train(2, 3, T / 5);
        rst = 1'b1; repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R7 mid reset sec", int'(sec_count_o), 0);
        check("R7 mid reset min", int'(min_count_o), 0);
        train(3, 7, (3 * T) / 10);
        idle(2 * T);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule